// File: doc/BRIEF.md
# Oversampling Serial Receiver with Two-Entry Buffer

This block turns an asynchronous serial line into parallel words. The line idles high. A frame starts with a low start bit, carries 8 or 9 data bits least-significant first, and ends with a high stop bit. Every bit period is split into 16 sub-bit ticks. The value of each bit is a 2-of-3 vote taken over the samples at the centre of the bit. The bits are collected in a shift register. When the stop bit has been sampled, the word is pushed into a two-entry first-in-first-out buffer. Each entry also holds the ninth bit and a framing-error flag.

Software sees a ready flag and an interrupt request while the buffer holds data. A one-cycle read strobe removes the oldest entry. In 9-bit mode the ninth bit tags a word as an address (1) or as plain data (0). Because the buffer has two entries, two finished words can wait while a third frame is still arriving. A frame that completes while both entries are occupied is discarded, and a sticky overrun flag records the loss.

Top module: `serial_rx_fifo2`

## Requirements
- R1: After reset, rx_ready, rx_irq and rx_overrun are 0.
- R2: A frame is a low start bit, then 8 data bits LSB first, then a stop bit. Each bit lasts 16 ticks and one tick lasts TICK_DIV clocks (default 4, so 64 clocks per bit). After the stop bit, rx_data shows the 8 data bits with bit 0 as the first bit received.
- R3: With nine_en=1 a ninth data bit follows bit 7 and appears on rx_ninth, where 1 marks an address and 0 marks data. With nine_en=0, rx_ninth reads 0.
- R4: Each bit value is the 2-of-3 majority of the samples at ticks 7, 8 and 9 of that bit, so a glitch that corrupts one of those samples does not change the received word.
- R5: A low level counts as a start bit only if the majority at the centre of the start bit is low. A shorter low pulse produces no entry.
- R6: A stop bit sampled as 0 stores rx_ferr=1 with that entry. A stop bit sampled as 1 stores rx_ferr=0.
- R7: The buffer holds two entries and returns them in arrival order, each with its own ninth bit and framing flag. rx_ready is 1 while the buffer holds at least one entry. A rd_pop pulse removes the head, and rx_ready falls when the last entry is read.
- R8: If a stop bit completes while both entries are full and no pop happens in that cycle, the frame is dropped and the two stored entries stay unchanged. rx_overrun then goes to 1 and stays 1 until an ovr_clr pulse; if a drop and ovr_clr happen in the same cycle, the set wins.
- R9: A rd_pop while the buffer is empty has no effect, and the next frame is received intact.
- R10: rx_irq equals rx_ready AND irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| nine_en | input | 1 | 1 selects 9 data bits per frame |
| irq_en | input | 1 | Interrupt request enable |
| rd_pop | input | 1 | Single-cycle read strobe; removes the head entry |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rx_data | output | 8 | Data byte of the head entry |
| rx_ninth | output | 1 | Ninth bit of the head entry (1 = address) |
| rx_ferr | output | 1 | Framing error of the head entry |
| rx_ready | output | 1 | Buffer holds at least one entry |
| rx_irq | output | 1 | Interrupt request |
| rx_overrun | output | 1 | Sticky flag: a frame was lost because the buffer was full |

## Verification
The main path is driven with several data patterns:
- Alternating and all-equal bytes check bit order and the end bits of the word.
- 9-bit frames with the ninth bit at 1 and at 0 show that the address tag travels with its own word rather than a neighbour's.
- A frame with a one-sample glitch at the centre of a data bit separates a true majority vote from single-sample capture.
- A short low pulse on an idle line separates start-bit validation from plain edge detection.

With reads held off, three frames are sent, one of them carrying a stop-bit error. This shows that entries keep their order and their flags, that the third frame is dropped without touching the two stored entries, and that the overrun flag stays set until it is cleared.

// File: rtl/srx_pkg.sv
// Shared types for the serial receiver.
// Assumes an 8-bit word plus an optional ninth bit.
package srx_pkg;
    localparam int DATA_W = 8;
    localparam int OSR    = 16;

    typedef struct packed {
        logic              ferr;
        logic              ninth;
        logic [DATA_W-1:0] data;
    } srx_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } srx_state_t;
endpackage

// File: rtl/srx_tick_gen.sv
// Free-running divider that produces one oversampling tick every TICK_DIV clocks.
// Assumes TICK_DIV >= 1; the tick is a single-cycle strobe.
module srx_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;

    // Count clocks and strobe on the last count of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            tick  <= 1'b0;
        end else if (div_q == LAST) begin
            div_q <= '0;
            tick  <= 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/srx_deframer.sv
// Recovers one frame at a time from the synchronised line.
// Each bit spans 16 ticks. The bit value is the majority of the samples at
// ticks 7, 8 and 9. A start bit whose centre votes high is rejected.
// The word is emitted at the centre of the stop bit.
// Assumes nine_en is stable for the length of a frame.
module srx_deframer
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    input  logic       nine_en,
    output logic       push,
    output srx_entry_t push_entry
);
    localparam logic [3:0] VOTE_AT = 4'd9;
    localparam logic [3:0] END_AT  = 4'(OSR - 1);

    srx_state_t  state_q;
    logic [3:0]  cnt_q;
    logic [1:0]  win_q;
    logic [3:0]  bit_q;
    logic [8:0]  sh_q;
    logic        maj;
    logic [3:0]  last_bit;

    // Majority of the two previous samples and the current one.
    always_comb begin
        maj      = (win_q[1] & win_q[0]) | (win_q[1] & rx_s) | (win_q[0] & rx_s);
        last_bit = nine_en ? 4'd8 : 4'd7;
    end

    // Frame sequencer: start check, data capture, stop check and push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            win_q      <= 2'b11;
            bit_q      <= '0;
            sh_q       <= '0;
            push       <= 1'b0;
            push_entry <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                win_q <= {win_q[0], rx_s};
                if (state_q == ST_IDLE) begin
                    if (!rx_s) begin
                        state_q <= ST_START;
                        cnt_q   <= 4'd1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    unique case (state_q)
                        ST_START: begin
                            if (cnt_q == VOTE_AT && maj) begin
                                state_q <= ST_IDLE;
                            end else if (cnt_q == END_AT) begin
                                state_q <= ST_DATA;
                                bit_q   <= '0;
                                sh_q    <= '0;
                            end
                        end
                        ST_DATA: begin
                            if (cnt_q == VOTE_AT) begin
                                sh_q[bit_q] <= maj;
                            end
                            if (cnt_q == END_AT) begin
                                if (bit_q == last_bit) begin
                                    state_q <= ST_STOP;
                                end else begin
                                    bit_q <= bit_q + 1'b1;
                                end
                            end
                        end
                        ST_STOP: begin
                            if (cnt_q == VOTE_AT) begin
                                push             <= 1'b1;
                                push_entry.data  <= sh_q[7:0];
                                push_entry.ninth <= nine_en & sh_q[8];
                                push_entry.ferr  <= ~maj;
                                state_q          <= ST_IDLE;
                            end
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    // R2: a word is only emitted out of the stop-bit state.
    a_r2_push_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(state_q == ST_STOP));

    // R5: a start bit that votes high at its centre returns to idle.
    a_r5_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && tick && cnt_q == VOTE_AT && maj) |=> state_q == ST_IDLE);

    // R3: the bit index never passes the ninth bit.
    a_r3_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= 4'd8);
endmodule

// File: rtl/srx_fifo2.sv
// Two-entry first-in-first-out buffer for received words.
// A push into a full buffer is dropped unless a pop happens in the same cycle.
// A pop on an empty buffer is ignored.
module srx_fifo2
    import srx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  srx_entry_t wdata,
    input  logic       pop,
    output srx_entry_t head,
    output logic       not_empty,
    output logic       full,
    output logic       drop
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    srx_entry_t    mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          pop_ok, push_ok;

    // Work out which requests are accepted this cycle.
    always_comb begin
        not_empty = (cnt_q != '0);
        full      = (cnt_q == CW'(DEPTH));
        pop_ok    = pop & not_empty;
        push_ok   = push & (~full | pop_ok);
        drop      = push & ~push_ok;
        head      = mem_q[rd_q];
    end

    // Entry storage, one write port per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (push_ok && wr_q == PW'(g)) begin
                mem_q[g] <= wdata;
            end
        end
    end

    // Pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop_ok)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R7: occupancy never exceeds the depth.
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R9: a pop on an empty buffer leaves it empty.
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && pop && !push) |=> cnt_q == '0);

    // R8: a dropped push leaves the stored head untouched.
    a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(head)));
endmodule

// File: rtl/serial_rx_fifo2.sv
// Top of the oversampling serial receiver.
// Synchronises the line, recovers frames, buffers two entries and keeps the
// sticky overrun flag. Assumes the line idles high.
module serial_rx_fifo2
    import srx_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int DEPTH    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic       nine_en,
    input  logic       irq_en,
    input  logic       rd_pop,
    input  logic       ovr_clr,
    output logic [7:0] rx_data,
    output logic       rx_ninth,
    output logic       rx_ferr,
    output logic       rx_ready,
    output logic       rx_irq,
    output logic       rx_overrun
);
    logic [1:0] sync_q;
    logic       tick;
    logic       push;
    logic       fifo_full;
    logic       drop;
    srx_entry_t push_entry;
    srx_entry_t head;

    // Two-flop synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_line};
    end

    srx_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    srx_deframer i_deframer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rx_s       (sync_q[1]),
        .nine_en    (nine_en),
        .push       (push),
        .push_entry (push_entry)
    );

    srx_fifo2 #(.DEPTH(DEPTH)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .wdata     (push_entry),
        .pop       (rd_pop),
        .head      (head),
        .not_empty (rx_ready),
        .full      (fifo_full),
        .drop      (drop)
    );

    // Sticky overrun flag: a drop sets it and wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_overrun <= 1'b0;
        else if (drop)    rx_overrun <= 1'b1;
        else if (ovr_clr) rx_overrun <= 1'b0;
    end

    // Present the head entry and the interrupt request.
    always_comb begin
        rx_data  = head.data;
        rx_ninth = head.ninth;
        rx_ferr  = head.ferr;
        rx_irq   = rx_ready & irq_en;
    end

    // R8: overrun only rises when the buffer was full.
    a_r8_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(fifo_full));

    // R8: overrun holds until cleared.
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !ovr_clr) |=> rx_overrun);
endmodule

// File: tb/test_serial_rx_fifo2.sv
`timescale 1ns/1ps
module test_serial_rx_fifo2;
    localparam int BIT_CLKS = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       nine_en = 1'b0;
    logic       irq_en = 1'b1;
    logic       mon_rd = 1'b0;
    logic       extra_rd = 1'b0;
    logic       rd_pop;
    logic       ovr_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ninth, rx_ferr, rx_ready, rx_irq, rx_overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit auto_rd = 1'b1;
    int reads_pending = 0;
    bit done = 1'b0;
    logic [9:0] exp_q [$];

    assign rd_pop = mon_rd | extra_rd;

    always #2 clk = ~clk;

    serial_rx_fifo2 i_serial_rx_fifo2 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .nine_en(nine_en),
        .irq_en(irq_en), .rd_pop(rd_pop), .ovr_clr(ovr_clr),
        .rx_data(rx_data), .rx_ninth(rx_ninth), .rx_ferr(rx_ferr),
        .rx_ready(rx_ready), .rx_irq(rx_irq), .rx_overrun(rx_overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: sends one frame and queues its expected entry if it is kept.
    // glitch_bit >= 0 inverts one centre sample of that data bit.
    task automatic send(input logic [8:0] d, input logic stop_v,
                        input bit keep, input int glitch_bit);
        int nb;
        nb = nine_en ? 9 : 8;
        if (keep) exp_q.push_back({~stop_v, nine_en & d[8], d[7:0]});
        @(negedge clk);
        rx_line = 1'b0;
        idle(BIT_CLKS);
        for (int i = 0; i < nb; i++) begin
            rx_line = d[i];
            if (i == glitch_bit) begin
                idle(33);
                rx_line = ~d[i];
                idle(4);
                rx_line = d[i];
                idle(BIT_CLKS - 37);
            end else begin
                idle(BIT_CLKS);
            end
        end
        rx_line = stop_v;
        idle(BIT_CLKS);
        rx_line = 1'b1;
        idle(96);
    endtask

    // Monitor: reads entries when allowed and compares with the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_rd) begin
                mon_rd = 1'b0;
            end else if (rx_ready && (auto_rd || reads_pending > 0)) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected entry", {rx_ferr, rx_ninth, rx_data}, 32'h3ff);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    check("R2/R3/R6/R7 entry", {rx_ferr, rx_ninth, rx_data}, e);
                end
                if (reads_pending > 0) reads_pending--;
                mon_rd = 1'b1;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check("R1 ready", rx_ready, 0);
        check("R1 irq", rx_irq, 0);
        check("R1 overrun", rx_overrun, 0);
        idle(50);

        // R2 8-bit patterns
        send(9'h055, 1'b1, 1, -1);
        send(9'h0A3, 1'b1, 1, -1);
        send(9'h000, 1'b1, 1, -1);
        send(9'h0FF, 1'b1, 1, -1);
        // R3 ninth bit ignored in 8-bit mode (d[8]=1 must read as 0)
        send(9'h13C, 1'b1, 1, -1);

        // R3 9-bit mode: address and data words
        nine_en = 1'b1;
        idle(10);
        send(9'h181, 1'b1, 1, -1);
        send(9'h07E, 1'b1, 1, -1);
        nine_en = 1'b0;
        idle(10);

        // R4 single-sample glitch in data bits 2 and 5
        send(9'h0C5, 1'b1, 1, 2);
        send(9'h0C5, 1'b1, 1, 5);

        // R6 framing error
        send(9'h0E7, 1'b0, 1, -1);
        idle(40);
        check("R7 ready low after drain", rx_ready, 0);

        // R5 short low pulse produces no entry
        rx_line = 1'b0;
        idle(16);
        rx_line = 1'b1;
        idle(4 * BIT_CLKS);
        check("R5 no entry after short pulse", rx_ready, 0);

        // R9 pop on empty is ignored
        extra_rd = 1'b1;
        idle(3);
        extra_rd = 1'b0;
        idle(4);
        check("R9 still empty", rx_ready, 0);
        send(9'h09D, 1'b1, 1, -1);
        idle(40);

        // R7/R8 buffer two entries, drop the third
        auto_rd = 1'b0;
        send(9'h011, 1'b0, 1, -1);
        check("R7 ready with one entry", rx_ready, 1);
        send(9'h022, 1'b1, 1, -1);
        // R10 interrupt follows ready and enable
        check("R10 irq with enable", rx_irq, 1);
        irq_en = 1'b0;
        idle(2);
        check("R10 irq masked", rx_irq, 0);
        irq_en = 1'b1;
        check("R8 no overrun yet", rx_overrun, 0);
        send(9'h033, 1'b1, 0, -1);
        check("R8 overrun set", rx_overrun, 1);
        check("R8 head unchanged", rx_data, 8'h11);
        reads_pending = 2;
        idle(20);
        check("R7 empty after two reads", rx_ready, 0);
        check("R8 overrun sticky", rx_overrun, 1);
        ovr_clr = 1'b1;
        idle(1);
        ovr_clr = 1'b0;
        idle(2);
        check("R8 overrun cleared", rx_overrun, 0);
        auto_rd = 1'b1;
        idle(20);
        check("R7 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule